// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Array

This block is a one-time-programmable AND-OR logic array. Sixteen data inputs each feed two array lines, the true value and its inverse. Sixty-four product terms can take any set of those 32 lines. The terms form eight groups of eight, and each group is ORed into one output. Every output passes through a polarity stage that can be flipped once. The outputs are combinational in the data inputs. The only clocked state is the fuse storage.

The fuses are reached through a port that works like a one-bit-wide PROM. A flat cell address selects either one array fuse, one polarity fuse, or the lock fuse. A blow strobe sampled on the clock edge clears the addressed fuse. A combinational read returns the state of the addressed fuse. Blowing the lock fuse closes the port: reads stop showing the fuse map and blow requests have no effect. The programmed logic keeps working while the port is closed. Reset puts every fuse back in the intact state, which models a fresh, unprogrammed part.

Top module: `fuse_sop_array`

## Requirements
- R1: After reset every fuse is intact, so for any input `data_o` is 8'h00 and `verify_o` reads 1 at every address.
- R2: Array line 2i carries `data_i[i]` and line 2i+1 carries its inverse. A product term is the AND of the lines whose fuses are still intact, so a term with all 32 fuses blown is constantly 1.
- R3: The equation with code e is the OR of product lines e*8 through e*8+7.
- R4: The polarity fuse of equation e sits at address 2048+e. While it is intact the output equals the OR result; once it is blown the output is the inverse of the OR result.
- R5: The array fuse address is {1'b0, code[2:0], term[2:0], pair[3:0], cmp}. That is the cell number product_line*32 + line, where line = pair*2 + cmp and cmp=1 selects the inverted line.
- R6: Equation codes 0..7 drive `data_o` bits 7,0,6,1,5,2,4,3 in that order.
- R7: A high `blow_i` at a rising clock edge clears the fuse at `prog_addr_i`, provided the array is not locked. `verify_o` shows the fuse at the current `prog_addr_i` combinationally: 1 for intact, 0 for blown. A blown fuse reads 0 from the cycle after the blow.
- R8: The lock fuse is at address 2056 and reads 1 while intact. Once it is blown it stays blown, and `verify_o` is 1 for every address.
- R9: While locked, `blow_i` changes no array or polarity fuse, so `data_o` for a given input stays the same as before the blow.
- R10: Addresses 2057..4095 hold no fuse. They read 1, and blowing them changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for fuse writes |
| rst_ni | input | 1 | Active-low asynchronous reset, restores all fuses |
| data_i | input | 16 | Array inputs |
| data_o | output | 8 | Array outputs, in physical order |
| prog_addr_i | input | 12 | Fuse cell address |
| blow_i | input | 1 | Blow request for the addressed fuse |
| verify_o | output | 1 | Readback of the addressed fuse (1 = intact) |

## Verification
The first pattern is the unprogrammed array. It shows that every term holds both a line and its inverse, and so stays 0. Directed single-literal terms come next: with one line kept, a term follows one input, which tells the true line apart from the inverted one and exposes any error in the code-to-output order. Terms with two literals, ORed with a second term in the same group, separate the AND inside a term from the OR across terms. A term with every fuse removed shows the constant-1 case. Random input vectors, applied after random two-literal terms and after polarity blows, are compared against a bench model. Readback at random addresses before and after locking separates array, polarity, lock and unused regions.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  typedef enum logic [1:0] {
    KIND_CELL,
    KIND_POL,
    KIND_LOCK,
    KIND_NONE
  } addr_kind_e;

  // physical output order: even codes fill from the top bit, odd codes from bit 0
  function automatic int code_to_bit(int code, int n_out);
    return (code % 2 == 0) ? (n_out - 1 - code / 2) : (code / 2);
  endfunction

endpackage

// File: rtl/sop_addr_dec.sv
`timescale 1ns/1ps
module sop_addr_dec #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned CELLS  = 2048,
  parameter int unsigned CELL_W = $clog2(CELLS),
  parameter int unsigned POL_W  = $clog2(N_OUT),
  parameter int unsigned ADDR_W = CELL_W + 1
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output sop_pkg::addr_kind_e   kind_o,
  output logic [CELL_W-1:0]     cell_idx_o,
  output logic [POL_W-1:0]      pol_idx_o
);
  localparam logic [ADDR_W-1:0] POL_BASE = ADDR_W'(CELLS);
  localparam logic [ADDR_W-1:0] LOCK_AD  = ADDR_W'(CELLS + N_OUT);

  assign cell_idx_o = addr_i[CELL_W-1:0];
  assign pol_idx_o  = addr_i[POL_W-1:0];

  always_comb begin
    if (addr_i < POL_BASE)      kind_o = sop_pkg::KIND_CELL;
    else if (addr_i < LOCK_AD)  kind_o = sop_pkg::KIND_POL;
    else if (addr_i == LOCK_AD) kind_o = sop_pkg::KIND_LOCK;
    else                        kind_o = sop_pkg::KIND_NONE;
  end
endmodule

// File: rtl/sop_fuse_store.sv
`timescale 1ns/1ps
module sop_fuse_store #(
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned CELLS  = 2048,
  parameter int unsigned CELL_W = $clog2(CELLS),
  parameter int unsigned POL_W  = $clog2(N_OUT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                blow_i,
  input  sop_pkg::addr_kind_e kind_i,
  input  logic [CELL_W-1:0]   cell_idx_i,
  input  logic [POL_W-1:0]    pol_idx_i,
  output logic [CELLS-1:0]    arr_o,
  output logic [N_OUT-1:0]    pol_o,
  output logic                lock_o,
  output logic                verify_o
);
  logic [CELLS-1:0] arr_q;   // 1 = intact
  logic [N_OUT-1:0] pol_q;   // 1 = intact
  logic             lock_q;  // 1 = lock fuse blown
  logic             wr_en;

  assign wr_en = blow_i & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      arr_q <= '1;
    else if (wr_en && kind_i == sop_pkg::KIND_CELL)   arr_q[cell_idx_i] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      pol_q <= '1;
    else if (wr_en && kind_i == sop_pkg::KIND_POL)    pol_q[pol_idx_i] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      lock_q <= 1'b0;
    else if (wr_en && kind_i == sop_pkg::KIND_LOCK)   lock_q <= 1'b1;
  end

  always_comb begin
    unique case (kind_i)
      sop_pkg::KIND_CELL: verify_o = arr_q[cell_idx_i];
      sop_pkg::KIND_POL:  verify_o = pol_q[pol_idx_i];
      default:            verify_o = 1'b1;
    endcase
    if (lock_q) verify_o = 1'b1;
  end

  assign arr_o  = arr_q;
  assign pol_o  = pol_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/sop_plane.sv
`timescale 1ns/1ps
module sop_plane #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned TERMS = 8,
  parameter int unsigned LINES = 2 * N_IN,
  parameter int unsigned PLINES = N_OUT * TERMS,
  parameter int unsigned CELLS = PLINES * LINES
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [CELLS-1:0] arr_i,
  input  logic [N_OUT-1:0] pol_i,
  output logic [N_OUT-1:0] out_o
);
  logic [LINES-1:0]  line;
  logic [PLINES-1:0] term;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    assign line[2*i]   = in_i[i];
    assign line[2*i+1] = ~in_i[i];
  end

  // intact fuse connects its line; blown fuse forces that input of the AND high
  for (genvar p = 0; p < PLINES; p++) begin : g_term
    assign term[p] = &(line | ~arr_i[p*LINES +: LINES]);
  end

  for (genvar e = 0; e < N_OUT; e++) begin : g_sum
    localparam int BIT = sop_pkg::code_to_bit(e, N_OUT);
    assign out_o[BIT] = (|term[e*TERMS +: TERMS]) ^ ~pol_i[e];
  end
endmodule

// File: rtl/fuse_sop_array.sv
`timescale 1ns/1ps
module fuse_sop_array #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned TERMS = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_IN-1:0]                       data_i,
  output logic [N_OUT-1:0]                      data_o,
  input  logic [$clog2(2*N_IN*N_OUT*TERMS):0]   prog_addr_i,
  input  logic                                  blow_i,
  output logic                                  verify_o
);
  localparam int unsigned LINES  = 2 * N_IN;
  localparam int unsigned PLINES = N_OUT * TERMS;
  localparam int unsigned CELLS  = PLINES * LINES;
  localparam int unsigned CELL_W = $clog2(CELLS);
  localparam int unsigned POL_W  = $clog2(N_OUT);
  localparam int unsigned ADDR_W = CELL_W + 1;

  sop_pkg::addr_kind_e kind;
  logic [CELL_W-1:0]   cell_idx;
  logic [POL_W-1:0]    pol_idx;
  logic [CELLS-1:0]    arr;
  logic [N_OUT-1:0]    pol;
  logic                lock_q;

  sop_addr_dec #(
    .N_OUT(N_OUT), .CELLS(CELLS), .CELL_W(CELL_W), .POL_W(POL_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr_i     (prog_addr_i),
    .kind_o     (kind),
    .cell_idx_o (cell_idx),
    .pol_idx_o  (pol_idx)
  );

  sop_fuse_store #(
    .N_OUT(N_OUT), .CELLS(CELLS), .CELL_W(CELL_W), .POL_W(POL_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blow_i     (blow_i),
    .kind_i     (kind),
    .cell_idx_i (cell_idx),
    .pol_idx_i  (pol_idx),
    .arr_o      (arr),
    .pol_o      (pol),
    .lock_o     (lock_q),
    .verify_o   (verify_o)
  );

  sop_plane #(
    .N_IN(N_IN), .N_OUT(N_OUT), .TERMS(TERMS)
  ) u_plane (
    .in_i  (data_i),
    .arr_i (arr),
    .pol_i (pol),
    .out_o (data_o)
  );
endmodule

// File: rtl/sop_chk.sv
`timescale 1ns/1ps
module sop_chk #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned TERMS = 8,
  parameter int unsigned CELLS = 2 * N_IN * N_OUT * TERMS,
  parameter int unsigned ADDR_W = $clog2(CELLS) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IN-1:0]   data_i,
  input logic [N_OUT-1:0]  data_o,
  input logic [ADDR_W-1:0] prog_addr_i,
  input logic              blow_i,
  input logic              verify_o,
  input logic              lock_i
);
  localparam logic [ADDR_W-1:0] CELL_END = ADDR_W'(CELLS);
  localparam logic [ADDR_W-1:0] LOCK_AD  = ADDR_W'(CELLS + N_OUT);

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  assert_locked_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> verify_o);

  assert_locked_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && blow_i) ##1 $stable(data_i) |-> $stable(data_o));

  assert_blow_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blow_i && !lock_i && prog_addr_i < CELL_END) ##1 $stable(prog_addr_i) |-> !verify_o);

  assert_unused_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_addr_i > LOCK_AD) |-> verify_o);
endmodule

bind fuse_sop_array sop_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .TERMS(TERMS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_i      (data_i),
  .data_o      (data_o),
  .prog_addr_i (prog_addr_i),
  .blow_i      (blow_i),
  .verify_o    (verify_o),
  .lock_i      (lock_q)
);

// File: tb/tb_fuse_sop_array.sv
`timescale 1ns/1ps
module tb_fuse_sop_array;
  localparam int NO = 8;
  localparam int CL = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic [7:0]  dout;
  logic [11:0] addr = '0;
  logic        blow = 1'b0;
  logic        ver;

  always #5 clk = ~clk;

  fuse_sop_array dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .data_o(dout),
    .prog_addr_i(addr), .blow_i(blow), .verify_o(ver)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit ref_arr[CL];
  bit ref_pol[NO];
  bit ref_lock;

  function automatic int bit_of(int code);
    case (code)
      0: return 7; 1: return 0; 2: return 6; 3: return 1;
      4: return 5; 5: return 2; 6: return 4; default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] ref_out(logic [15:0] x);
    logic [7:0] o = '0;
    for (int e = 0; e < NO; e++) begin
      bit s = 0;
      for (int t = 0; t < 8; t++) begin
        bit tm = 1;
        int p = e * 8 + t;
        for (int i = 0; i < 16; i++) begin
          if (ref_arr[p*32 + 2*i])     tm = tm & x[i];
          if (ref_arr[p*32 + 2*i + 1]) tm = tm & ~x[i];
        end
        s = s | tm;
      end
      o[bit_of(e)] = ref_pol[e] ? s : ~s;
    end
    return o;
  endfunction

  function automatic bit ref_ver(int a);
    if (ref_lock)     return 1'b1;
    if (a < CL)       return ref_arr[a];
    if (a < CL + NO)  return ref_pol[a - CL];
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_in(string req, logic [15:0] x);
    @(negedge clk);
    din = x;
    #2;
    chk(req, 32'(dout), 32'(ref_out(x)));
  endtask

  task automatic rand_outs(string req, int n);
    for (int k = 0; k < n; k++) apply_in(req, 16'($urandom));
  endtask

  task automatic read_chk(string req, int a);
    @(negedge clk);
    addr = 12'(a);
    #2;
    chk(req, 32'(ver), 32'(ref_ver(a)));
  endtask

  task automatic do_blow(int a);
    @(negedge clk);
    addr = 12'(a);
    blow = 1'b1;
    @(posedge clk);
    if (!ref_lock) begin
      if (a < CL)           ref_arr[a] = 0;
      else if (a < CL + NO) ref_pol[a - CL] = 0;
      else if (a == CL + NO) ref_lock = 1;
    end
    @(negedge clk);
    blow = 1'b0;
  endtask

  task automatic shape_term(int code, int term, logic [31:0] keep);
    for (int l = 0; l < 32; l++)
      if (!keep[l]) do_blow(code * 256 + term * 32 + l);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < CL; i++) ref_arr[i] = 1;
    for (int i = 0; i < NO; i++) ref_pol[i] = 1;
    ref_lock = 0;
    #23 rst_n = 1'b1;

    // R1: blank array
    rand_outs("R1", 8);
    apply_in("R1", 16'hFFFF);
    chk("R1", 32'(dout), 32'h0);
    for (int k = 0; k < 8; k++) read_chk("R1", int'($urandom % 4096));

    // R2 R5 R6: single true literal x0 in code 0 term 0 -> bit 7
    shape_term(0, 0, 32'h1);
    apply_in("R6", 16'h0001);
    chk("R6", 32'(dout), 32'h80);
    apply_in("R2", 16'hFFFE);
    chk("R2", 32'(dout), 32'h00);

    // R3: code 1 term 3 = x1 & ~x2, term 5 = x3 -> bit 0
    shape_term(1, 3, (32'h1 << 2) | (32'h1 << 5));
    shape_term(1, 5, 32'h1 << 6);
    apply_in("R3", 16'h0002);
    chk("R3", 32'(dout[0]), 32'h1);
    apply_in("R3", 16'h0008);
    chk("R3", 32'(dout[0]), 32'h1);
    apply_in("R3", 16'h0006);
    chk("R3", 32'(dout[0]), 32'h0);
    rand_outs("R3", 16);

    // R2: term with every fuse blown -> code 6 (bit 4) constant 1
    shape_term(6, 2, 32'h0);
    rand_outs("R2", 8);
    chk("R2", 32'(dout[4]), 32'h1);

    // R5: random two-literal terms
    for (int c = 2; c < 8; c++) begin
      if (c == 6) continue;
      shape_term(c, int'($urandom % 8), (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32)));
    end
    rand_outs("R5", 24);

    // R4: polarity fuses
    do_blow(CL + 3);
    do_blow(CL + 6);
    rand_outs("R4", 16);
    chk("R4", 32'(dout[4]), 32'h0);

    // R7: readback
    read_chk("R7", 1);
    chk("R7", 32'(ver), 32'h0);
    read_chk("R7", 0);
    chk("R7", 32'(ver), 32'h1);
    for (int k = 0; k < 64; k++) read_chk("R7", int'($urandom % (CL + NO)));
    for (int k = 0; k < NO; k++) read_chk("R7", CL + k);

    // R10: unused addresses
    do_blow(2060);
    do_blow(4095);
    read_chk("R10", 2060);
    chk("R10", 32'(ver), 32'h1);
    read_chk("R10", 4095);
    rand_outs("R10", 8);

    // R8: lock fuse
    read_chk("R8", CL + NO);
    chk("R8", 32'(ver), 32'h1);
    do_blow(CL + NO);
    read_chk("R8", 1);
    chk("R8", 32'(ver), 32'h1);
    read_chk("R8", CL + 3);
    for (int k = 0; k < 16; k++) read_chk("R8", int'($urandom % 4096));

    // R9: blows ignored while locked
    do_blow(0);
    do_blow(CL + 1);
    do_blow(CL + 6 * 0 + 2);
    apply_in("R9", 16'h0000);
    chk("R9", 32'(dout[7]), 32'h0);
    rand_outs("R9", 16);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule